// File: doc/BRIEF.md
# Camera Stream Byte and Line Decimator

This block sits on the 8-bit parallel pixel bus of a camera capture path, ahead of the stage that packs bytes into storage words. It reduces the stream in two independent ways. Byte decimation keeps one byte out of every pair. This pulls the luma samples out of interleaved YUV422, and a select bit chooses between the luma-first order (Y U Y V) and the chroma-first order (U Y V Y). Line decimation keeps one line out of every pair, and a select bit chooses whether the even or the odd lines survive.

A frame begins on the rising edge of the vertical sync input. A line is active while the horizontal sync input is high. A byte is accepted in a cycle where both the valid strobe and horizontal sync are high. The byte-pair phase restarts at every line start. The line-pair phase restarts at every frame start. The four control bits are captured only at frame start, so one frame is always decimated in one way throughout. Kept bytes come out one clock later with a valid strobe. Both sync signals are passed through with the same one-clock delay.

Top module: `cam_thin_top`

## Requirements
- R1: With byte decimation on and byte select 0, only the 1st, 3rd, 5th, ... accepted bytes of each line are output (luma from Y U Y V order).
- R2: With byte decimation on and byte select 1, only the 2nd, 4th, 6th, ... accepted bytes of each line are output (luma from U Y V Y order).
- R3: The byte-pair phase restarts at each rising edge of horizontal sync, so the first accepted byte of every line counts as the first of a pair, even when the previous line had an odd byte count.
- R4: With line decimation off, every line is passed, whatever the value of the line select bit.
- R5: With line decimation on and line select 0, lines 0, 2, 4, ... of a frame are passed and lines 1, 3, 5, ... produce no output.
- R6: With line decimation on and line select 1, lines 1, 3, 5, ... of a frame are passed and lines 0, 2, 4, ... produce no output.
- R7: The line-pair phase restarts at each rising edge of vertical sync, so line 0 of every frame counts as the first line of a pair, even when the previous frame had an odd line count.
- R8: The control bits are captured on the rising edge of vertical sync. Changes made later in the frame take effect from the next frame.
- R9: A kept byte appears on the data output with the valid output high exactly one clock after it was accepted. Dropped bytes, and bytes presented with horizontal sync low, never raise the valid output.
- R10: The horizontal and vertical sync outputs equal the corresponding inputs delayed by one clock.
- R11: After reset all outputs are 0 and the captured control bits are 0, so data arriving before the first frame start passes unchanged, whatever the control inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input byte strobe |
| in_hsync | input | 1 | Line active level (high during a line) |
| in_vsync | input | 1 | Frame marker; its rising edge starts a frame |
| in_data | input | 8 | Input pixel byte |
| cfg_byte_en | input | 1 | Byte decimation enable |
| cfg_byte_sel | input | 1 | 0 keeps the first byte of each pair, 1 keeps the second |
| cfg_line_en | input | 1 | Line decimation enable |
| cfg_line_sel | input | 1 | 0 keeps even lines, 1 keeps odd lines |
| out_vld | output | 1 | Output byte strobe |
| out_data | output | 8 | Output pixel byte |
| out_hsync | output | 1 | Horizontal sync delayed by one clock |
| out_vsync | output | 1 | Vertical sync delayed by one clock |

## Verification
The hardest cases to reach are the phase restarts. A wrong design looks correct as long as every line has an even byte count and every frame has an even line count. The stimulus therefore drives lines with an odd number of bytes and frames with an odd number of lines back to back, so that a phase left over from the previous line or frame would shift which bytes survive. Gaps in the valid strobe inside a line check that the phase advances on accepted bytes only. A frame in which every control bit is flipped just after the vertical sync edge checks that the captured settings hold for the whole frame.

// File: rtl/cam_thin_pkg.sv
package cam_thin_pkg;

    // Decimation settings, held for one frame
    typedef struct packed {
        logic byte_en;
        logic byte_sel;
        logic line_en;
        logic line_sel;
    } thin_cfg_t;

    // Edge events of a sync level
    typedef struct packed {
        logic start;
        logic stop;
    } sync_ev_t;

    localparam thin_cfg_t CFG_PASS_ALL = '0;

    // A pair phase survives when decimation is off or the phase matches the select
    function automatic logic phase_keeps(input logic en, input logic sel, input logic ph);
        return !en || (ph == sel);
    endfunction

endpackage

// File: rtl/cam_sync_edge.sv
module cam_sync_edge
    import cam_thin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     lvl,
    output sync_ev_t ev
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    always_comb begin
        ev.start = lvl & ~lvl_q;
        ev.stop  = ~lvl & lvl_q;
    end
endmodule

// File: rtl/cam_phase_track.sv
module cam_phase_track
    import cam_thin_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_ev_t  frame_ev,
    input  sync_ev_t  line_ev,
    input  logic      accept,
    input  thin_cfg_t cfg_in,
    output thin_cfg_t cfg_eff,
    output logic      byte_ph_eff,
    output logic      line_ph_eff,
    output thin_cfg_t cfg_q,
    output logic      line_ph_q
);
    logic byte_ph_q;
    logic byte_ph_n;
    logic line_ph_n;
    thin_cfg_t cfg_n;

    always_comb begin
        // Settings and line phase take their new frame values in the edge cycle itself
        cfg_eff     = frame_ev.start ? cfg_in : cfg_q;
        line_ph_eff = frame_ev.start ? 1'b0 : line_ph_q;
        byte_ph_eff = line_ev.start  ? 1'b0 : byte_ph_q;

        cfg_n = cfg_eff;

        if (frame_ev.start)     line_ph_n = 1'b0;
        else if (line_ev.stop)  line_ph_n = ~line_ph_q;
        else                    line_ph_n = line_ph_q;

        if (accept)                              byte_ph_n = ~byte_ph_eff;
        else if (line_ev.start || frame_ev.stop) byte_ph_n = 1'b0;
        else                                     byte_ph_n = byte_ph_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_PASS_ALL;
            line_ph_q <= 1'b0;
            byte_ph_q <= 1'b0;
        end else begin
            cfg_q     <= cfg_n;
            line_ph_q <= line_ph_n;
            byte_ph_q <= byte_ph_n;
        end
    end
endmodule

// File: rtl/cam_emit.sv
module cam_emit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              keep,
    input  logic [DATA_W-1:0] data_in,
    input  logic              hs_in,
    input  logic              vs_in,
    output logic              vld_out,
    output logic [DATA_W-1:0] data_out,
    output logic              hs_out,
    output logic              vs_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_out  <= 1'b0;
            data_out <= '0;
            hs_out   <= 1'b0;
            vs_out   <= 1'b0;
        end else begin
            vld_out <= keep;
            hs_out  <= hs_in;
            vs_out  <= vs_in;
            if (keep) data_out <= data_in;
        end
    end
endmodule

// File: rtl/cam_thin_top.sv
module cam_thin_top
    import cam_thin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic              in_hsync,
    input  logic              in_vsync,
    input  logic [DATA_W-1:0] in_data,
    input  logic              cfg_byte_en,
    input  logic              cfg_byte_sel,
    input  logic              cfg_line_en,
    input  logic              cfg_line_sel,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data,
    output logic              out_hsync,
    output logic              out_vsync
);
    sync_ev_t  line_ev;
    sync_ev_t  frame_ev;
    thin_cfg_t cfg_in;
    thin_cfg_t cfg_eff;
    thin_cfg_t cfg_act;
    logic      byte_ph_eff;
    logic      line_ph_eff;
    logic      line_ph_q;
    logic      accept;
    logic      keep;

    always_comb begin
        cfg_in.byte_en  = cfg_byte_en;
        cfg_in.byte_sel = cfg_byte_sel;
        cfg_in.line_en  = cfg_line_en;
        cfg_in.line_sel = cfg_line_sel;
    end

    cam_sync_edge line_edge_i (.clk(clk), .rst(rst), .lvl(in_hsync), .ev(line_ev));
    cam_sync_edge frame_edge_i (.clk(clk), .rst(rst), .lvl(in_vsync), .ev(frame_ev));

    assign accept = in_vld & in_hsync;

    cam_phase_track track_i (
        .clk        (clk),
        .rst        (rst),
        .frame_ev   (frame_ev),
        .line_ev    (line_ev),
        .accept     (accept),
        .cfg_in     (cfg_in),
        .cfg_eff    (cfg_eff),
        .byte_ph_eff(byte_ph_eff),
        .line_ph_eff(line_ph_eff),
        .cfg_q      (cfg_act),
        .line_ph_q  (line_ph_q)
    );

    assign keep = accept
                & phase_keeps(cfg_eff.byte_en, cfg_eff.byte_sel, byte_ph_eff)
                & phase_keeps(cfg_eff.line_en, cfg_eff.line_sel, line_ph_eff);

    cam_emit #(.DATA_W(DATA_W)) emit_i (
        .clk     (clk),
        .rst     (rst),
        .keep    (keep),
        .data_in (in_data),
        .hs_in   (in_hsync),
        .vs_in   (in_vsync),
        .vld_out (out_vld),
        .data_out(out_data),
        .hs_out  (out_hsync),
        .vs_out  (out_vsync)
    );
endmodule

// File: rtl/cam_thin_chk.sv
module cam_thin_chk
    import cam_thin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic              in_hsync,
    input logic              in_vsync,
    input logic [DATA_W-1:0] in_data,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_data,
    input logic              out_hsync,
    input logic              out_vsync,
    input thin_cfg_t         act_cfg,
    input logic              line_ph
);
    // R9: output strobe only follows an accepted byte
    p_vld_from_accept_r9: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld && in_hsync));

    // R9: output byte is the byte accepted one clock earlier
    p_data_delay_r9: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> out_data == $past(in_data));

    // R1/R2: with byte decimation, kept bytes never come out back to back
    p_byte_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (out_vld && act_cfg.byte_en) |=> !out_vld);

    // R5/R6: output only on lines whose phase matches the select
    p_line_phase_r5: assert property (@(posedge clk) disable iff (rst)
        (out_vld && act_cfg.line_en) |-> line_ph == act_cfg.line_sel);

    // R10: sync signals delayed by one clock
    p_hsync_delay_r10: assert property (@(posedge clk) disable iff (rst)
        in_hsync |=> out_hsync);
    p_vsync_delay_r10: assert property (@(posedge clk) disable iff (rst)
        !in_vsync |=> !out_vsync);
endmodule

bind cam_thin_top cam_thin_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_hsync (in_hsync),
    .in_vsync (in_vsync),
    .in_data  (in_data),
    .out_vld  (out_vld),
    .out_data (out_data),
    .out_hsync(out_hsync),
    .out_vsync(out_vsync),
    .act_cfg  (cfg_act),
    .line_ph  (line_ph_q)
);

// File: tb/cam_thin_top_tb_top.sv
module cam_thin_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic       in_hsync = 1'b0;
    logic       in_vsync = 1'b0;
    logic [7:0] in_data = '0;
    logic       cfg_byte_en = 1'b0;
    logic       cfg_byte_sel = 1'b0;
    logic       cfg_line_en = 1'b0;
    logic       cfg_line_sel = 1'b0;
    logic       out_vld;
    logic [7:0] out_data;
    logic       out_hsync;
    logic       out_vsync;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    cam_thin_top dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_hsync(in_hsync), .in_vsync(in_vsync),
        .in_data(in_data), .cfg_byte_en(cfg_byte_en), .cfg_byte_sel(cfg_byte_sel),
        .cfg_line_en(cfg_line_en), .cfg_line_sel(cfg_line_sel), .out_vld(out_vld),
        .out_data(out_data), .out_hsync(out_hsync), .out_vsync(out_vsync)
    );

    // Monitor: inputs only change at falling edges, so just after a rising edge
    // the outputs reflect the inputs that are still on the pins.
    always @(posedge clk) begin
        #2;
        if (!rst && !done) begin
            checks++;
            if (out_hsync !== in_hsync || out_vsync !== in_vsync) begin
                failures++;
                $display("FAIL R10 sync actual=%b%b expected=%b%b", out_hsync, out_vsync, in_hsync, in_vsync);
            end
            if (out_vld === 1'b1) begin
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R9 unexpected byte actual=%h expected=none", out_data);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (out_data !== e) begin
                        failures++;
                        $display("FAIL %s data actual=%h expected=%h", t, out_data, e);
                    end
                end
            end
        end
    end

    task automatic check_drained(input string tag);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL %s missing bytes actual=%0d expected=0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Drives one line; expectations use the settings the bench knows are in force
    task automatic drive_line(input int li, input int len, input bit gappy,
                              input bit be, input bit bs, input bit le, input bit ls,
                              input string tag);
        automatic int bi = 0;
        automatic int cyc = 0;
        automatic bit keep_l = !le || ((li % 2) == int'(ls));
        @(negedge clk);
        in_hsync = 1'b1;
        while (bi < len) begin
            if (gappy && (cyc % 3 == 2)) begin
                in_vld = 1'b0;
            end else begin
                in_vld  = 1'b1;
                in_data = 8'(li * 16 + bi);
                if (keep_l && (!be || ((bi % 2) == int'(bs)))) begin
                    exp_q.push_back(in_data);
                    tag_q.push_back(tag);
                end
                bi++;
            end
            cyc++;
            @(negedge clk);
        end
        in_vld   = 1'b0;
        in_hsync = 1'b0;
        // bytes while hsync is low are never accepted (R9)
        @(negedge clk);
        in_vld  = 1'b1;
        in_data = 8'hEE;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic run_frame(input bit be, input bit bs, input bit le, input bit ls,
                             input int nlines, input int len, input bit gappy,
                             input bit mid_flip, input string tag);
        @(negedge clk);
        cfg_byte_en = be; cfg_byte_sel = bs; cfg_line_en = le; cfg_line_sel = ls;
        in_vsync = 1'b1;
        @(negedge clk);
        if (mid_flip) begin
            cfg_byte_en = ~be; cfg_byte_sel = ~bs; cfg_line_en = ~le; cfg_line_sel = ~ls;
        end
        for (int li = 0; li < nlines; li++)
            drive_line(li, len, gappy, be, bs, le, ls, tag);
        in_vsync = 1'b0;
        check_drained(tag);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state of the outputs
        checks++;
        if (out_vld !== 1'b0 || out_data !== 8'h00 || out_hsync !== 1'b0 || out_vsync !== 1'b0) begin
            failures++;
            $display("FAIL R11 reset actual=%b%h%b%b expected=0000", out_vld, out_data, out_hsync, out_vsync);
        end
        // R11: before any frame start the captured settings are pass-all
        cfg_byte_en = 1'b1; cfg_byte_sel = 1'b1; cfg_line_en = 1'b1; cfg_line_sel = 1'b1;
        drive_line(0, 6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        check_drained("R11");

        run_frame(0, 0, 0, 0, 3, 6, 1, 0, "R9");   // all passed, gapped strobe
        run_frame(1, 0, 0, 0, 2, 8, 0, 0, "R1");   // Y U Y V
        run_frame(1, 1, 0, 0, 2, 8, 1, 0, "R2");   // U Y V Y, gapped
        run_frame(1, 0, 0, 0, 3, 5, 0, 0, "R3");   // odd-length lines
        run_frame(1, 1, 0, 0, 3, 7, 1, 0, "R3");
        run_frame(0, 0, 0, 1, 4, 4, 0, 0, "R4");   // line select ignored
        run_frame(0, 0, 1, 0, 5, 4, 0, 0, "R5");
        run_frame(0, 0, 1, 1, 5, 4, 1, 0, "R6");
        run_frame(0, 0, 1, 0, 3, 4, 0, 0, "R7");   // odd line count, twice
        run_frame(0, 0, 1, 0, 3, 4, 0, 0, "R7");
        run_frame(0, 0, 1, 1, 3, 4, 0, 0, "R7");
        run_frame(1, 0, 1, 0, 4, 6, 0, 1, "R8");   // settings flipped mid-frame
        run_frame(0, 1, 0, 1, 3, 6, 0, 0, "R8");   // flipped values now ignored until captured
        run_frame(1, 1, 1, 1, 4, 9, 1, 0, "R2");   // both decimations together

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule